// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a register-mapped general-purpose I/O controller for up to 64 pins; the default build has 36. Each pin has a drive-enable bit and a drive value that go straight to the pad. Pad levels come back through a two-flop synchronizer, and software can read them at any time. The level is reported even for a pin that is currently driving, so software can compare the line against its own settings.

Every pin detects one edge. A polarity bit chooses which edge: 0 selects rising and 1 selects falling. A detected edge sets a sticky flag whether or not that pin's interrupt is enabled. The combined interrupt line is asserted while any flag is set on an enabled pin. A separate wake-up request is asserted while any flag is set on a pin whose wake bit is set. To see both edges on a pin, software flips that pin's polarity bit after each event. Flags are cleared by writing 1 to them.

Each register is a pair of 32-bit words: the low word holds pins 0 to 31 and the high word holds pins 32 and up. There are two windows, selected by `reg_win`. The word index is `reg_addr`, and the byte offset is four times the index.
- Data window (`reg_win`=0): drive-enable at index 0/1, pad level at index 4/5 (read-only), drive value at index 6/7.
- Interrupt window (`reg_win`=1): interrupt enable at 0/1, polarity at 2/3, flags at 4/5, wake enable at 6/7.

Reads are combinational. A write takes effect on the clock edge where `reg_we` is high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` and `pad_out` are 0, and `irq_out` and `wake_out` are low.
- R2: A write to the drive-enable or drive-value register appears on `pad_oe` or `pad_out` right after the writing clock edge. Bit i of the high word (index 1 or 7) controls pin 32+i, and a drive-enable bit of 1 makes the pin drive.
- R3: The pad-level register (data index 4/5) shows the pad 2 clock edges after the pad changes and not after 1 edge. This also holds while the pin is driving.
- R4: With polarity bit 0 only a rising pad edge sets the pin's flag, and with polarity bit 1 only a falling edge does. The flag is set on the 3rd clock edge after the pad changes.
- R5: A flag is set whether or not the pin's interrupt is enabled. `irq_out` is high exactly while some flag is set on an enabled pin.
- R6: Writing a word to the flag register clears each flag whose written bit is 1 and leaves flags whose written bit is 0 unchanged.
- R7: When an edge is detected on the same clock edge as a 1 is written to that pin's flag, the flag stays set.
- R8: `wake_out` is high exactly while some flag is set on a pin whose wake-enable bit is 1. It does not depend on interrupt enable.
- R9: Register bits for pins at or above NUM_PINS read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe |
| reg_win | input | 1 | Window select: 0 data, 1 interrupt |
| reg_addr | input | 3 | Word index in the window; bit 0 selects the high word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Pad drive values |
| pad_oe | output | NUM_PINS | Pad drive enables |
| irq_out | output | 1 | Combined interrupt |
| wake_out | output | 1 | Wake-up request |

## Verification
The bench changes pads and register inputs on the falling clock edge and samples half a cycle after each rising edge. Register effects on the pads, and flag clears, are checked right after the writing edge. Pad levels are checked after exactly one rising edge (still old) and after two (new). Flags are checked after three rising edges. In the R7 case the clear write is timed to land on that same third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 64;

  typedef enum logic [1:0] {
    DSEL_DIR   = 2'd0,
    DSEL_NONE  = 2'd1,
    DSEL_LEVEL = 2'd2,
    DSEL_DRIVE = 2'd3
  } data_sel_e;

  typedef enum logic [1:0] {
    ISEL_EN   = 2'd0,
    ISEL_POL  = 2'd1,
    ISEL_FLAG = 2'd2,
    ISEL_WAKE = 2'd3
  } irq_sel_e;

  // configuration register slots
  localparam int CFG_DIR   = 0;
  localparam int CFG_DRIVE = 1;
  localparam int CFG_EN    = 2;
  localparam int CFG_POL   = 3;
  localparam int CFG_WAKE  = 4;
  localparam int CFG_N     = 5;

  function automatic logic [WORD_W-1:0] lane_get(logic [VEC_W-1:0] v, logic hi);
    return hi ? v[VEC_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  function automatic logic [VEC_W-1:0] lane_put(logic [VEC_W-1:0] v,
                                                logic [WORD_W-1:0] w, logic hi);
    logic [VEC_W-1:0] r;
    r = v;
    if (hi) r[VEC_W-1:WORD_W] = w;
    else    r[WORD_W-1:0]     = w;
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] lane_spread(logic [WORD_W-1:0] w, logic hi);
    return hi ? {w, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, w};
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign evt[i] = pol[i] ? (prev_q[i] & ~level[i]) : (level[i] & ~prev_q[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag_q
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic                reg_win,
  input  logic [2:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_out,
  output logic                wake_out
);
  logic [1:0]          sel;
  logic                hi;
  logic [CFG_N-1:0]    cfg_we;
  logic [NUM_PINS-1:0] cfg_q [CFG_N];
  logic [NUM_PINS-1:0] level_sync;
  logic [NUM_PINS-1:0] evt_vec;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] flag_q;
  logic [VEC_W-1:0]    rd_vec;

  assign sel = reg_addr[2:1];
  assign hi  = reg_addr[0];

  always_comb begin
    cfg_we = '0;
    if (reg_we && !reg_win) begin
      cfg_we[CFG_DIR]   = (sel == DSEL_DIR);
      cfg_we[CFG_DRIVE] = (sel == DSEL_DRIVE);
    end
    if (reg_we && reg_win) begin
      cfg_we[CFG_EN]   = (sel == ISEL_EN);
      cfg_we[CFG_POL]  = (sel == ISEL_POL);
      cfg_we[CFG_WAKE] = (sel == ISEL_WAKE);
    end
  end

  genvar c;
  generate
    for (c = 0; c < CFG_N; c++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q[c] <= '0;
        else if (cfg_we[c])
          cfg_q[c] <= NUM_PINS'(lane_put(64'(cfg_q[c]), reg_wdata, hi));
      end
    end
  endgenerate

  gpio_in_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(level_sync)
  );

  gpio_edge_detect #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level_sync), .pol(cfg_q[CFG_POL]), .evt(evt_vec)
  );

  assign clr_vec = (reg_we && reg_win && sel == ISEL_FLAG)
                 ? NUM_PINS'(lane_spread(reg_wdata, hi)) : '0;

  gpio_flag_bank #(.W(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_vec), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  always_comb begin
    rd_vec = '0;
    if (!reg_win) begin
      case (sel)
        DSEL_DIR:   rd_vec = 64'(cfg_q[CFG_DIR]);
        DSEL_LEVEL: rd_vec = 64'(level_sync);
        DSEL_DRIVE: rd_vec = 64'(cfg_q[CFG_DRIVE]);
        default:    rd_vec = '0;
      endcase
    end else begin
      case (sel)
        ISEL_EN:   rd_vec = 64'(cfg_q[CFG_EN]);
        ISEL_POL:  rd_vec = 64'(cfg_q[CFG_POL]);
        ISEL_FLAG: rd_vec = 64'(flag_q);
        default:   rd_vec = 64'(cfg_q[CFG_WAKE]);
      endcase
    end
  end

  assign reg_rdata = lane_get(rd_vec, hi);
  assign pad_oe    = cfg_q[CFG_DIR];
  assign pad_out   = cfg_q[CFG_DRIVE];
  assign irq_out   = |(flag_q & cfg_q[CFG_EN]);
  assign wake_out  = |(flag_q & cfg_q[CFG_WAKE]);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_PINS = 36
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq_out,
  input logic                wake_out,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] wake_q,
  input logic [NUM_PINS-1:0] evt_vec,
  input logic [NUM_PINS-1:0] clr_vec
);
  AST_PAD_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pad_oe)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~$past(clr_vec)) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_vec) & ~flag_q) == '0)); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (flag_q != '0)); // R5

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q == '0) |-> !wake_out); // R8
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .pad_oe(pad_oe),
  .irq_out(irq_out), .wake_out(wake_out), .flag_q(flag_q),
  .en_q(cfg_q[2]), .wake_q(cfg_q[4]), .evt_vec(evt_vec), .clr_vec(clr_vec)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  localparam int N = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic          reg_win = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pads = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq_out, wake_out;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_win(reg_win),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic win, logic [2:0] idx, logic [31:0] d);
    reg_win = win; reg_addr = idx; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic win, logic [2:0] idx, output logic [31:0] d);
    reg_win = win; reg_addr = idx;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic clear_flags();
    wr(1, 4, 32'hFFFF_FFFF);
    wr(1, 5, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 0, d); chk("R1 dir lo", d, 0);
    rd(1, 2, d); chk("R1 pol lo", d, 0);
    rd(1, 4, d); chk("R1 flag lo", d, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq/wake", {irq_out, wake_out}, 0);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    wr(0, 0, 32'hA5A5_0F0F);
    chk("R2 pad_oe lo", pad_oe, 36'h0_A5A5_0F0F);
    wr(0, 1, 32'hFFFF_FFFF);
    chk("R2 pad_oe hi", pad_oe[35:32], 4'hF);
    rd(0, 1, d); chk("R9 dir hi readback", d, 32'h0000_000F);
    wr(0, 7, 32'h0000_0015);
    chk("R2 pad_out hi", pad_out, 36'h5_0000_0000);
    rd(0, 7, d); chk("R9 drive hi readback", d, 32'h5);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pads[3] = 1'b1; pads[33] = 1'b1;
    tick(1);
    rd(0, 4, d); chk("R3 level lo after 1 edge", d, 0);
    tick(1);
    rd(0, 4, d); chk("R3 level lo after 2 edges", d, 32'h8);
    rd(0, 5, d); chk("R3 level hi on driving pin", d, 32'h2);
    tick(1);
    rd(1, 4, d); chk("R5 flag set with irq disabled", d, 32'h8);
    chk("R5 irq low when disabled", irq_out, 0);
    clear_flags();
    pads[3] = 1'b0; pads[33] = 1'b0;
    tick(4);
    rd(1, 4, d); chk("R4 falling ignored at pol 0", d, 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(1, 2, 32'h0000_0020);
    pads[5] = 1'b1; tick(4);
    rd(1, 4, d); chk("R4 rising ignored at pol 1", d, 0);
    pads[5] = 1'b0; tick(2);
    rd(1, 4, d); chk("R4 flag not yet after 2 edges", d, 0);
    tick(1);
    rd(1, 4, d); chk("R4 falling sets at pol 1", d, 32'h20);
    pads[6] = 1'b1; tick(3);
    rd(1, 4, d); chk("R4 rising sets at pol 0", d, 32'h60);
    wr(1, 4, 32'h40);
    pads[6] = 1'b0; tick(4);
    rd(1, 4, d); chk("R4 falling on pol-0 pin ignored", d, 32'h20);
  endtask

  task automatic t_irq();
    wr(1, 0, 32'h20);
    chk("R5 irq high on enabled flag", irq_out, 1);
    wr(1, 4, 32'h20);
    chk("R5 irq low after clear", irq_out, 0);
    wr(1, 0, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clear_flags();
    pads[1:0] = 2'b11; tick(3);
    rd(1, 4, d); chk("R6 both flags set", d, 32'h3);
    wr(1, 4, 32'h1);
    rd(1, 4, d); chk("R6 only written-1 bit cleared", d, 32'h2);
    wr(1, 4, 32'h0);
    rd(1, 4, d); chk("R6 zero write leaves flags", d, 32'h2);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pads[0] = 1'b0; tick(4);
    wr(1, 4, 32'h3);
    pads[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(1, 4, 32'h1);
    rd(1, 4, d); chk("R7 edge beats clear", d, 32'h1);
    wr(1, 4, 32'h1);
    rd(1, 4, d); chk("R7 clear alone works", d, 32'h0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(1, 7, 32'h4);
    pads[34] = 1'b1; tick(3);
    rd(1, 5, d); chk("R8 hi flag set", d, 32'h4);
    chk("R8 wake high", wake_out, 1);
    chk("R8 irq stays low", irq_out, 0);
    wr(1, 5, 32'h4);
    chk("R8 wake low after clear", wake_out, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(1, 1, 32'hFFFF_FFFF);
    rd(1, 1, d); chk("R9 en hi upper bits zero", d, 32'hF);
    wr(1, 3, 32'hFFFF_FFF0);
    rd(1, 3, d); chk("R9 pol hi upper bits zero", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_drive();
    t_input();
    t_edges();
    t_irq();
    t_w1c();
    t_race();
    t_wake();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule